// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet controller and decides, frame by frame, whether the frame is kept. The first destination address bytes arrive one per strobe. As they stream past, the block compares them against a programmed station address and also tests them for broadcast and multicast. The result of the address test is fixed when the last destination byte arrives. When the end-of-frame pulse comes, the block combines that result with the final byte count and a reset-packet indication, then issues a one-cycle verdict.

Software programs the block through a small byte-wide write port. Six byte registers hold the station address, and one further register holds the receive mode. The mode selects one of four acceptance levels. It also turns on three optional behaviours: matching on a shortened address, keeping short frames, and keeping reset packets. CRC checking and frame storage happen elsewhere.

Top module: `rx_dest_filter`

## Requirements
- R1: With mode level bits [1:0] = 00, every frame is rejected.
- R2: With level 01, a frame is accepted when its destination equals the station address, or when all six destination bytes are 0xFF. Every other destination is rejected.
- R3: With level 10, multicast frames are also accepted. A frame is multicast when bit 0 of its first destination byte is 1.
- R4: With level 11, a frame is accepted whatever its destination.
- R5: A write with `cfg_sel` 0 to 5 loads station address byte 0 (first on the wire) to byte 5. A write with `cfg_sel` 6 loads the mode register. A write with `cfg_sel` 7 changes nothing.
- R6: With mode bit 4 set, the sixth destination byte is left out of the station address comparison. Bytes one to five must still match.
- R7: A frame whose `rx_len` is below 64 and whose address test passed is rejected with `runt_evt` high, unless mode bit 3 is set. When mode bit 3 is set, the frame is judged as a full-length frame and `runt_evt` stays low.
- R8: A frame marked by `rx_rst_pkt` is rejected unless mode bit 2 is set. `rstpkt_evt` pulses exactly when such a frame is accepted.
- R9: `dec_vld` is high for the single cycle after each clock edge that samples `rx_eof`, and only then. `dec_accept`, `runt_evt` and `rstpkt_evt` are high only together with `dec_vld`.
- R10: A frame that ends before six destination bytes have arrived is rejected in every mode.
- R11: Mode bits 7:5 have no effect on any decision.
- R12: During reset and after it, before any frame ends, all four decision outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0..5 address bytes, 6 mode |
| cfg_wdata | input | 8 | Configuration write data |
| rx_sof | input | 1 | Start-of-frame pulse, in a cycle before the first byte |
| rx_vld | input | 1 | Frame byte strobe |
| rx_data | input | 8 | Frame byte |
| rx_eof | input | 1 | End-of-frame pulse, after the last byte |
| rx_len | input | LEN_W | Final byte count, sampled with `rx_eof` |
| rx_rst_pkt | input | 1 | Frame is a reset packet, sampled with `rx_eof` |
| dec_vld | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Frame accepted |
| runt_evt | output | 1 | Short frame rejected |
| rstpkt_evt | output | 1 | Reset packet accepted |

## Verification
The bench builds the block with its defaults: six address bytes, a 64-byte minimum and an 11-bit count. With those values it can sweep every level, the shortened-match flag, both option flags, lengths on either side of the 64 boundary and the reset-packet marker, each against six kinds of destination. Together these cover all of the mode space that matters to a decision. Directed frames add the truncated header, the unused register offset and the inert mode bits.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CFG_SEL_W = 3;

  typedef enum logic [1:0] {
    LVL_NONE  = 2'b00,
    LVL_UNIBC = 2'b01,
    LVL_MCAST = 2'b10,
    LVL_ALL   = 2'b11
  } rxf_level_e;

  typedef struct packed {
    logic       partial;
    logic       en_runt;
    logic       en_rst;
    rxf_level_e level;
  } rxf_mode_t;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_SEL_W-1:0]          cfg_sel,
  input  logic [7:0]                    cfg_wdata,
  output logic [ADDR_BYTES-1:0][7:0]    sta_addr,
  output rxf_mode_t                     mode
);
  localparam logic [CFG_SEL_W-1:0] MODE_SEL = CFG_SEL_W'(ADDR_BYTES);

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_sta
    logic byte_en;
    assign byte_en = cfg_we && (cfg_sel == CFG_SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sta_addr[i] <= '0;
      else if (byte_en) sta_addr[i] <= cfg_wdata;
    end
  end

  logic mode_en;
  assign mode_en = cfg_we && (cfg_sel == MODE_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode <= '0;
    else if (mode_en) mode <= rxf_mode_t'(cfg_wdata[4:0]);
  end
endmodule

// File: rtl/rxf_addr_cmp.sv
module rxf_addr_cmp
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sof,
  input  logic                       byte_vld,
  input  logic [7:0]                 byte_data,
  input  logic [ADDR_BYTES-1:0][7:0] sta_addr,
  input  logic                       partial,
  input  rxf_level_e                 level,
  output logic                       dest_done,
  output logic                       dest_hit
);
  localparam int CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0]      cnt_q, cnt_n;
  logic                  own_q, own_n, bc_q, bc_n, mc_q, mc_n;
  logic                  done_n, hit_n;
  logic [ADDR_BYTES-1:0] pos_eq;
  logic                  cur_eq, take;

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_eq
    logic skip;
    assign skip      = partial && (i == ADDR_BYTES - 1);
    assign pos_eq[i] = (cnt_q == CNT_W'(i)) && (skip || byte_data == sta_addr[i]);
  end

  assign cur_eq = |pos_eq;
  assign take   = byte_vld && !dest_done;

  always_comb begin
    cnt_n  = cnt_q;
    own_n  = own_q;
    bc_n   = bc_q;
    mc_n   = mc_q;
    done_n = dest_done;
    hit_n  = dest_hit;
    if (sof) begin
      cnt_n  = '0;
      own_n  = 1'b1;
      bc_n   = 1'b1;
      mc_n   = 1'b0;
      done_n = 1'b0;
      hit_n  = 1'b0;
    end else if (take) begin
      own_n = own_q && cur_eq;
      bc_n  = bc_q && (byte_data == 8'hFF);
      if (cnt_q == '0) mc_n = byte_data[0];
      if (cnt_q == LAST) begin
        done_n = 1'b1;
        unique case (level)
          LVL_NONE:  hit_n = 1'b0;
          LVL_UNIBC: hit_n = own_n || bc_n;
          LVL_MCAST: hit_n = own_n || bc_n || mc_n;
          default:   hit_n = 1'b1;
        endcase
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      own_q     <= 1'b0;
      bc_q      <= 1'b0;
      mc_q      <= 1'b0;
      dest_done <= 1'b0;
      dest_hit  <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      own_q     <= own_n;
      bc_q      <= bc_n;
      mc_q      <= mc_n;
      dest_done <= done_n;
      dest_hit  <= hit_n;
    end
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide #(
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             rst_pkt,
  input  logic             dest_done,
  input  logic             dest_hit,
  input  logic             en_runt,
  input  logic             en_rst,
  output logic             dec_vld,
  output logic             dec_accept,
  output logic             runt_evt,
  output logic             rstpkt_evt
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  logic addr_ok, is_short, vld_n, acc_n, runt_n, rp_n;

  always_comb begin
    addr_ok  = dest_done && dest_hit;
    is_short = frame_len < MIN_L;
    vld_n    = eof;
    acc_n    = eof && addr_ok && (!is_short || en_runt) && (!rst_pkt || en_rst);
    runt_n   = eof && addr_ok && is_short && !en_runt;
    rp_n     = acc_n && rst_pkt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld    <= 1'b0;
      dec_accept <= 1'b0;
      runt_evt   <= 1'b0;
      rstpkt_evt <= 1'b0;
    end else begin
      dec_vld    <= vld_n;
      dec_accept <= acc_n;
      runt_evt   <= runt_n;
      rstpkt_evt <= rp_n;
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 11,
  parameter int MIN_LEN    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [7:0]       cfg_wdata,
  input  logic             rx_sof,
  input  logic             rx_vld,
  input  logic [7:0]       rx_data,
  input  logic             rx_eof,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             rx_rst_pkt,
  output logic             dec_vld,
  output logic             dec_accept,
  output logic             runt_evt,
  output logic             rstpkt_evt
);
  logic                       sync1_q, rst_sync_n;
  logic [ADDR_BYTES-1:0][7:0] sta_addr;
  rxf_mode_t                  mode;
  logic                       dest_done, dest_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      sync1_q    <= 1'b1;
      rst_sync_n <= sync1_q;
    end
  end

  rxf_cfg_regs #(.ADDR_BYTES(ADDR_BYTES)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sta_addr(sta_addr), .mode(mode)
  );

  rxf_addr_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
    .clk(clk), .rst_n(rst_sync_n), .sof(rx_sof), .byte_vld(rx_vld),
    .byte_data(rx_data), .sta_addr(sta_addr), .partial(mode.partial),
    .level(mode.level), .dest_done(dest_done), .dest_hit(dest_hit)
  );

  rxf_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_dec (
    .clk(clk), .rst_n(rst_sync_n), .eof(rx_eof), .frame_len(rx_len),
    .rst_pkt(rx_rst_pkt), .dest_done(dest_done), .dest_hit(dest_hit),
    .en_runt(mode.en_runt), .en_rst(mode.en_rst), .dec_vld(dec_vld),
    .dec_accept(dec_accept), .runt_evt(runt_evt), .rstpkt_evt(rstpkt_evt)
  );
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_eof,
  input logic dec_vld,
  input logic dec_accept,
  input logic runt_evt,
  input logic rstpkt_evt,
  input logic dest_done,
  input logic dest_hit
);
  p_vld_after_eof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(rx_eof));

  p_eof_to_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eof |=> dec_vld);

  p_events_framed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_accept || runt_evt || rstpkt_evt) |-> dec_vld);

  p_runt_rejects_r7: assert property (@(posedge clk) disable iff (!rst_n)
    runt_evt |-> !dec_accept);

  p_rstpkt_accepted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rstpkt_evt |-> dec_accept);

  p_accept_needs_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> $past(dest_done && dest_hit));
endmodule

bind rx_dest_filter rx_dest_filter_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rx_eof(rx_eof), .dec_vld(dec_vld),
  .dec_accept(dec_accept), .runt_evt(runt_evt), .rstpkt_evt(rstpkt_evt),
  .dest_done(dest_done), .dest_hit(dest_hit)
);

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
  localparam int CLK_P = 10;
  localparam logic [47:0] STA = 48'h12_34_56_78_9A_BC;

  logic        clk = 1'b0;
  logic        rst_n, cfg_we, rx_sof, rx_vld, rx_eof, rx_rst_pkt;
  logic [2:0]  cfg_sel;
  logic [7:0]  cfg_wdata, rx_data;
  logic [10:0] rx_len;
  logic        dec_vld, dec_accept, runt_evt, rstpkt_evt;
  int          errs = 0, checks = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_dest_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_data(rx_data),
    .rx_eof(rx_eof), .rx_len(rx_len), .rx_rst_pkt(rx_rst_pkt),
    .dec_vld(dec_vld), .dec_accept(dec_accept), .runt_evt(runt_evt),
    .rstpkt_evt(rstpkt_evt)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [47:0] dest_of(input int kind);
    case (kind)
      0: return STA;
      1: return STA ^ 48'h00_00_00_00_00_01;
      2: return STA ^ 48'h00_00_00_00_10_00;
      3: return 48'hFF_FF_FF_FF_FF_FF;
      4: return 48'h01_00_5E_00_00_01;
      default: return 48'h20_11_22_33_44_55;
    endcase
  endfunction

  function automatic bit addr_pass(input logic [47:0] d, input int lvl, input bit part);
    bit own = 1, bc = 1, mc;
    for (int i = 0; i < 6; i++) begin
      if (!(i == 5 && part) && d[47-8*i -: 8] != STA[47-8*i -: 8]) own = 0;
      if (d[47-8*i -: 8] != 8'hFF) bc = 0;
    end
    mc = d[40];
    case (lvl)
      0: return 0;
      1: return own || bc;
      2: return own || bc || mc;
      default: return 1;
    endcase
  endfunction

  task automatic run_frame(input logic [47:0] d, input int nb, input int len,
                           input bit rp, output bit v, output bit a,
                           output bit r, output bit p, output bit v_after);
    @(negedge clk);
    rx_sof = 1'b1;
    @(negedge clk);
    rx_sof = 1'b0;
    for (int i = 0; i < nb; i++) begin
      rx_vld = 1'b1; rx_data = d[47-8*i -: 8];
      @(negedge clk);
    end
    rx_vld = 1'b0;
    rx_eof = 1'b1; rx_len = 11'(len); rx_rst_pkt = rp;
    @(negedge clk);
    v = dec_vld; a = dec_accept; r = runt_evt; p = rstpkt_evt;
    rx_eof = 1'b0; rx_rst_pkt = 1'b0;
    @(negedge clk);
    v_after = dec_vld;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit v, a, r, p, va;
    string t;
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    rx_sof = 0; rx_vld = 0; rx_data = 0; rx_eof = 0; rx_len = 0; rx_rst_pkt = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset vld", dec_vld, 1'b0);
    chk("R12 reset accept", dec_accept, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 post-reset vld", dec_vld, 1'b0);
    chk("R12 post-reset runt", runt_evt, 1'b0);
    chk("R12 post-reset rstpkt", rstpkt_evt, 1'b0);

    // R5: address bytes at offsets 0..5, first wire byte at offset 0
    for (int i = 0; i < 6; i++) cfg_write(3'(i), STA[47-8*i -: 8]);
    cfg_write(3'd6, 8'h01);
    cfg_write(3'd7, 8'hFF);
    run_frame(STA, 6, 64, 0, v, a, r, p, va);
    chk("R5 own frame after offset-7 write", a, 1'b1);
    run_frame(dest_of(5), 6, 64, 0, v, a, r, p, va);
    chk("R5 offset-7 write left level unchanged", a, 1'b0);

    // R10: truncated destination
    cfg_write(3'd6, 8'h03);
    run_frame(STA, 3, 64, 0, v, a, r, p, va);
    chk("R10 short header rejected", a, 1'b0);
    chk("R10 short header still gives vld", v, 1'b1);

    // R11: bits 7:5 inert
    cfg_write(3'd6, 8'hE1);
    run_frame(dest_of(4), 6, 64, 0, v, a, r, p, va);
    chk("R11 spare bits, multicast at level 01", a, 1'b0);
    run_frame(STA, 6, 63, 0, v, a, r, p, va);
    chk("R11 spare bits, runt flagged", r, 1'b1);

    // Sweep
    for (int lvl = 0; lvl < 4; lvl++)
      for (int part = 0; part < 2; part++)
        for (int er = 0; er < 2; er++)
          for (int es = 0; es < 2; es++) begin
            cfg_write(3'd6, 8'((part << 4) | (er << 3) | (es << 2) | lvl));
            for (int k = 0; k < 6; k++)
              for (int sh = 0; sh < 2; sh++)
                for (int rp = 0; rp < 2; rp++) begin
                  bit ap, ea, eru, erp;
                  ap  = addr_pass(dest_of(k), lvl, bit'(part));
                  ea  = ap && (sh == 0 || er == 1) && (rp == 0 || es == 1);
                  eru = ap && sh == 1 && er == 0;
                  erp = ea && rp == 1;
                  run_frame(dest_of(k), 6, sh ? 63 : 64, bit'(rp), v, a, r, p, va);
                  t = (lvl == 0) ? "R1" : (lvl == 1) ? "R2" : (lvl == 2) ? "R3" : "R4";
                  if (part == 1 && k == 1) t = "R6";
                  chk({t, " accept"}, a, ea);
                  chk("R7 runt event", r, eru);
                  chk("R8 reset-packet event", p, erp);
                  chk("R9 vld on verdict", v, 1'b1);
                  chk("R9 vld single cycle", va, 1'b0);
                end
          end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule